// File: doc/BRIEF.md
# Translation Context Selector

This block sits in front of a page-table walker and settles, for one memory access, which translation context applies. It takes the current privilege level, the access kind, the hypervisor and virtualization flags, the status bits that can override privilege, and three root-pointer registers: native, guest-virtual and guest-physical. From these it works out the effective privilege, whether translation is bypassed, and which root applies. It then reports that root's base address, its level count and virtual-address width, the extra root-index width, the executable-readable flag in force and the supervisor-user-access flag.

A caller presents a request with `req_valid`. Exactly one cycle later the registered result appears with `out_valid`. One request can be accepted every cycle. A root register whose mode field holds an encoding the walker cannot handle is flagged with `bad_mode` instead of producing a context.

Top module: `xlat_ctx_sel`

## Requirements
- R1: While `rst` is high at a clock edge, every output register clears to zero, and `out_valid` is 0 afterwards until a request is accepted.
- R2: Each cycle with `req_valid` high yields exactly one result with `out_valid` high on the following cycle. A cycle without a request yields `out_valid` low on the following cycle.
- R3: When `cur_priv` is M (3) and `acc_kind` is not a fetch (fetch=0, load=1, store=2), a set `mprv` replaces the effective privilege with `mpp`. A fetch is never overridden.
- R4: In the R3 override, the guest-virtual root is selected when `hyp_en` and `mpv` are both set. Otherwise the native root is selected.
- R5: When the effective privilege is S (1), the access is not a fetch, `hyp_en` is set, `virt_on` is clear and `sprv` is set, the privilege becomes U (0) or S (1) according to `spp`, and the guest-virtual root is selected.
- R6: When `stage2` is set, the effective privilege is U, the guest-physical root is selected, and `idx_widen` is 2. When `stage2` is clear, `idx_widen` is 0.
- R7: The access is bypassed when the effective privilege is M, when `mmu_en` is clear, or when the selected mode field is bare (0). A bypassed access gives `pa_out` equal to `va` and `perm_rwx` equal to 3'b111.
- R8: `mxr_out` is taken from `mxr_vs` when `stage2` is set, and from `mxr_m` otherwise.
- R9: A root register carries its mode in bits [63:60] and its PPN in bits [43:0]. Mode 8 means 3 levels and mode 9 means 4 levels. A translated access gives `root_base` = PPN << 12, `mode_levels` = the level count, and `va_bits` = 12 + 9 × levels + `idx_widen`.
- R10: A mode field other than 0, 8 or 9 on an access that is not otherwise bypassed raises `bad_mode`. In that case `bypass` is 0, and `root_base`, `mode_levels`, `va_bits`, `pa_out` and `perm_rwx` are all 0.
- R11: `sum_out` returns the `sum_in` value of the same request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| acc_kind | input | 2 | Access kind (fetch=0, load=1, store=2) |
| hyp_en | input | 1 | Hypervisor support present |
| virt_on | input | 1 | Virtualization currently enabled |
| stage2 | input | 1 | Request is a guest-physical (second stage) lookup |
| mmu_en | input | 1 | Paging hardware present |
| mprv | input | 1 | Machine privilege-override enable |
| mpp | input | 2 | Privilege used under machine override |
| mpv | input | 1 | Machine override targets a virtualized guest |
| sprv | input | 1 | Supervisor privilege-override enable |
| spp | input | 1 | Privilege used under supervisor override (1=S) |
| mxr_m | input | 1 | Executable-readable flag, machine status |
| mxr_vs | input | 1 | Executable-readable flag, guest supervisor status |
| sum_in | input | 1 | Supervisor-user-access flag |
| va | input | 64 | Access address |
| root_native | input | 64 | Native root pointer |
| root_guest | input | 64 | Guest-virtual root pointer |
| root_gphys | input | 64 | Guest-physical root pointer |
| out_valid | output | 1 | Result present |
| eff_priv | output | 2 | Effective privilege |
| bypass | output | 1 | Translation bypassed |
| pa_out | output | 64 | Address when bypassed, else 0 |
| perm_rwx | output | 3 | Permissions when bypassed (bit2=R, bit1=W, bit0=X) |
| root_base | output | 56 | Root table base address |
| mode_levels | output | 3 | Page-table levels |
| idx_widen | output | 2 | Extra root-index bits |
| va_bits | output | 7 | Significant virtual-address bits |
| mxr_out | output | 1 | Executable-readable flag in force |
| sum_out | output | 1 | Supervisor-user-access flag |
| bad_mode | output | 1 | Unsupported mode encoding |

## Verification
Requests are built around a machine-mode load, store and fetch with and without `mprv`, which separates the override from its fetch exemption and the native root from the guest root depending on `hyp_en`/`mpv`. Supervisor requests with `sprv` are tried with virtualization on and off and as a fetch, which separates the three cases where the supervisor override applies or is blocked. Second-stage requests issued from machine privilege show whether the forced U privilege, the guest-physical root, the widening of 2 and the `mxr_vs` source all take effect together. Bare, 3-level, 4-level and reserved mode encodings, plus a request with `mmu_en` clear, separate the bypass, translate and `bad_mode` outcomes. Back-to-back requests and idle gaps confirm the one-cycle result spacing.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam int         MODE_W    = 4;
  localparam logic [3:0] MODE_BARE = 4'd0;
  localparam logic [3:0] MODE_L3   = 4'd8;
  localparam logic [3:0] MODE_L4   = 4'd9;

endpackage

// File: rtl/xlat_priv_resolve.sv
module xlat_priv_resolve
  import xlat_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic [1:0] acc_i,
  input  logic       hyp_i,
  input  logic       virt_i,
  input  logic       stage2_i,
  input  logic       mprv_i,
  input  logic [1:0] mpp_i,
  input  logic       mpv_i,
  input  logic       sprv_i,
  input  logic       spp_i,
  output logic [1:0] eff_o,
  output logic       guest_o
);

  logic [1:0] after_m;
  logic       guest_m;
  logic [1:0] after_s;
  logic       guest_s;
  logic       not_fetch;

  assign not_fetch = (acc_i != ACC_FETCH);

  // machine override step
  always_comb begin
    after_m = priv_i;
    guest_m = 1'b0;
    if ((priv_i == PRIV_M) && not_fetch && mprv_i) begin
      after_m = mpp_i;
      guest_m = hyp_i & mpv_i;
    end
  end

  // supervisor override step, only from a non-virtualized host
  always_comb begin
    after_s = after_m;
    guest_s = guest_m;
    if ((after_m == PRIV_S) && not_fetch && hyp_i && !virt_i && sprv_i) begin
      after_s = spp_i ? PRIV_S : PRIV_U;
      guest_s = 1'b1;
    end
  end

  // guest-physical lookups are always made as user
  assign eff_o   = stage2_i ? PRIV_U : after_s;
  assign guest_o = guest_s;

endmodule

// File: rtl/xlat_root_select.sv
module xlat_root_select #(
  parameter int XLEN     = 64,
  parameter int PPN_W    = 44,
  parameter int MODE_LSB = 60,
  parameter int S2_WIDEN = 2
) (
  input  logic             stage2_i,
  input  logic             guest_i,
  input  logic [XLEN-1:0]  root_native_i,
  input  logic [XLEN-1:0]  root_guest_i,
  input  logic [XLEN-1:0]  root_gphys_i,
  input  logic             mxr_m_i,
  input  logic             mxr_vs_i,
  output logic [PPN_W-1:0] ppn_o,
  output logic [3:0]       mode_o,
  output logic [1:0]       widen_o,
  output logic             mxr_o
);

  logic [XLEN-1:0] chosen;
  logic            unused_gap;

  always_comb begin
    if (stage2_i)     chosen = root_gphys_i;
    else if (guest_i) chosen = root_guest_i;
    else              chosen = root_native_i;
  end

  assign ppn_o      = chosen[PPN_W-1:0];
  assign mode_o     = chosen[MODE_LSB +: 4];
  assign unused_gap = ^chosen[MODE_LSB-1:PPN_W];
  assign widen_o    = stage2_i ? 2'(S2_WIDEN) : 2'd0;
  assign mxr_o      = stage2_i ? mxr_vs_i : mxr_m_i;

endmodule

// File: rtl/xlat_mode_decode.sv
module xlat_mode_decode
  import xlat_pkg::*;
#(
  parameter bit FOUR_LVL_EN = 1'b1
) (
  input  logic [3:0] mode_i,
  output logic [2:0] levels_o,
  output logic       ok_o,
  output logic       bare_o
);

  assign bare_o = (mode_i == MODE_BARE);

  generate
    if (FOUR_LVL_EN) begin : g_with_four
      always_comb begin
        case (mode_i)
          MODE_BARE: begin levels_o = 3'd0; ok_o = 1'b1; end
          MODE_L3:   begin levels_o = 3'd3; ok_o = 1'b1; end
          MODE_L4:   begin levels_o = 3'd4; ok_o = 1'b1; end
          default:   begin levels_o = 3'd0; ok_o = 1'b0; end
        endcase
      end
    end else begin : g_three_only
      always_comb begin
        case (mode_i)
          MODE_BARE: begin levels_o = 3'd0; ok_o = 1'b1; end
          MODE_L3:   begin levels_o = 3'd3; ok_o = 1'b1; end
          default:   begin levels_o = 3'd0; ok_o = 1'b0; end
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/xlat_ctx_sel.sv
module xlat_ctx_sel
  import xlat_pkg::*;
#(
  parameter int XLEN        = 64,
  parameter int PPN_W       = 44,
  parameter int MODE_LSB    = 60,
  parameter int PG_SHIFT    = 12,
  parameter int IDX_W       = 9,
  parameter int S2_WIDEN    = 2,
  parameter bit FOUR_LVL_EN = 1'b1,
  localparam int BASE_W     = PPN_W + PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        cur_priv,
  input  logic [1:0]        acc_kind,
  input  logic              hyp_en,
  input  logic              virt_on,
  input  logic              stage2,
  input  logic              mmu_en,
  input  logic              mprv,
  input  logic [1:0]        mpp,
  input  logic              mpv,
  input  logic              sprv,
  input  logic              spp,
  input  logic              mxr_m,
  input  logic              mxr_vs,
  input  logic              sum_in,
  input  logic [XLEN-1:0]   va,
  input  logic [XLEN-1:0]   root_native,
  input  logic [XLEN-1:0]   root_guest,
  input  logic [XLEN-1:0]   root_gphys,
  output logic              out_valid,
  output logic [1:0]        eff_priv,
  output logic              bypass,
  output logic [XLEN-1:0]   pa_out,
  output logic [2:0]        perm_rwx,
  output logic [BASE_W-1:0] root_base,
  output logic [2:0]        mode_levels,
  output logic [1:0]        idx_widen,
  output logic [6:0]        va_bits,
  output logic              mxr_out,
  output logic              sum_out,
  output logic              bad_mode
);

  logic [1:0]       eff_c;
  logic             guest_c;
  logic [PPN_W-1:0] ppn_c;
  logic [3:0]       mode_c;
  logic [1:0]       widen_c;
  logic             mxr_c;
  logic [2:0]       lvl_c;
  logic             ok_c;
  logic             bare_c;
  logic             bypass_c;
  logic             walk_c;
  logic             bad_c;

  xlat_priv_resolve u_priv (
    .priv_i   (cur_priv),
    .acc_i    (acc_kind),
    .hyp_i    (hyp_en),
    .virt_i   (virt_on),
    .stage2_i (stage2),
    .mprv_i   (mprv),
    .mpp_i    (mpp),
    .mpv_i    (mpv),
    .sprv_i   (sprv),
    .spp_i    (spp),
    .eff_o    (eff_c),
    .guest_o  (guest_c)
  );

  xlat_root_select #(
    .XLEN     (XLEN),
    .PPN_W    (PPN_W),
    .MODE_LSB (MODE_LSB),
    .S2_WIDEN (S2_WIDEN)
  ) u_root (
    .stage2_i      (stage2),
    .guest_i       (guest_c),
    .root_native_i (root_native),
    .root_guest_i  (root_guest),
    .root_gphys_i  (root_gphys),
    .mxr_m_i       (mxr_m),
    .mxr_vs_i      (mxr_vs),
    .ppn_o         (ppn_c),
    .mode_o        (mode_c),
    .widen_o       (widen_c),
    .mxr_o         (mxr_c)
  );

  xlat_mode_decode #(
    .FOUR_LVL_EN (FOUR_LVL_EN)
  ) u_mode (
    .mode_i   (mode_c),
    .levels_o (lvl_c),
    .ok_o     (ok_c),
    .bare_o   (bare_c)
  );

  assign bypass_c = (eff_c == PRIV_M) || !mmu_en || bare_c;
  assign bad_c    = !bypass_c && !ok_c;
  assign walk_c   = !bypass_c && ok_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      eff_priv    <= '0;
      bypass      <= 1'b0;
      pa_out      <= '0;
      perm_rwx    <= '0;
      root_base   <= '0;
      mode_levels <= '0;
      idx_widen   <= '0;
      va_bits     <= '0;
      mxr_out     <= 1'b0;
      sum_out     <= 1'b0;
      bad_mode    <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        eff_priv    <= eff_c;
        bypass      <= bypass_c;
        pa_out      <= bypass_c ? va : '0;
        perm_rwx    <= bypass_c ? 3'b111 : 3'b000;
        root_base   <= walk_c ? {ppn_c, {PG_SHIFT{1'b0}}} : '0;
        mode_levels <= walk_c ? lvl_c : 3'd0;
        va_bits     <= walk_c ? 7'(PG_SHIFT) + 7'(IDX_W) * {4'd0, lvl_c} + {5'd0, widen_c}
                              : 7'd0;
        idx_widen   <= widen_c;
        mxr_out     <= mxr_c;
        sum_out     <= sum_in;
        bad_mode    <= bad_c;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_result_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  assert_idle_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  assert_fetch_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && acc_kind == ACC_FETCH && cur_priv == PRIV_M && !stage2)
      |=> (eff_priv == PRIV_M) && bypass);

  assert_stage2_user_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && stage2) |=> (eff_priv == PRIV_U) && (idx_widen == 2'(S2_WIDEN)));

  assert_no_mmu_bypass_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mmu_en) |=> bypass && (perm_rwx == 3'b111));

  assert_bypass_grants_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && bypass) |-> (perm_rwx == 3'b111) && !bad_mode);

  assert_bad_mode_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && bad_mode) |-> !bypass && (root_base == '0) && (perm_rwx == 3'b000)
                                && (va_bits == 7'd0));

endmodule

// File: tb/xlat_ctx_sel_tb_top.sv
`timescale 1ns/1ps
module xlat_ctx_sel_tb_top;

  typedef struct packed {
    logic [1:0]  priv;
    logic [1:0]  acc;
    logic        hyp;
    logic        virt;
    logic        s2;
    logic        mmu;
    logic        mprv;
    logic [1:0]  mpp;
    logic        mpv;
    logic        sprv;
    logic        spp;
    logic        mxr_m;
    logic        mxr_vs;
    logic        sum;
    logic [63:0] va;
    logic [63:0] rn;
    logic [63:0] rg;
    logic [63:0] rgp;
  } stim_t;

  typedef struct packed {
    logic [1:0]  eff;
    logic        byp;
    logic [63:0] pa;
    logic [2:0]  perm;
    logic [55:0] base;
    logic [2:0]  lvls;
    logic [1:0]  widen;
    logic [6:0]  vab;
    logic        mxr;
    logic        sum;
    logic        bad;
  } res_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0;
  stim_t       cur = '0;
  logic        out_valid;
  logic [1:0]  eff_priv;
  logic        bypass;
  logic [63:0] pa_out;
  logic [2:0]  perm_rwx;
  logic [55:0] root_base;
  logic [2:0]  mode_levels;
  logic [1:0]  idx_widen;
  logic [6:0]  va_bits;
  logic        mxr_out;
  logic        sum_out;
  logic        bad_mode;

  xlat_ctx_sel dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .cur_priv(cur.priv), .acc_kind(cur.acc), .hyp_en(cur.hyp), .virt_on(cur.virt),
    .stage2(cur.s2), .mmu_en(cur.mmu), .mprv(cur.mprv), .mpp(cur.mpp), .mpv(cur.mpv),
    .sprv(cur.sprv), .spp(cur.spp), .mxr_m(cur.mxr_m), .mxr_vs(cur.mxr_vs),
    .sum_in(cur.sum), .va(cur.va), .root_native(cur.rn), .root_guest(cur.rg),
    .root_gphys(cur.rgp),
    .out_valid(out_valid), .eff_priv(eff_priv), .bypass(bypass), .pa_out(pa_out),
    .perm_rwx(perm_rwx), .root_base(root_base), .mode_levels(mode_levels),
    .idx_widen(idx_widen), .va_bits(va_bits), .mxr_out(mxr_out), .sum_out(sum_out),
    .bad_mode(bad_mode)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  res_t  exp_q[$];
  string tag_q[$];

  function automatic res_t model(stim_t s);
    res_t        e;
    logic [1:0]  p;
    logic        g;
    logic [63:0] r;
    logic [3:0]  m;
    logic        ok;
    logic [2:0]  lv;
    e = '0;
    p = s.priv;
    g = 1'b0;
    if (p == 2'd3 && s.acc != 2'd0 && s.mprv) begin p = s.mpp; g = s.hyp & s.mpv; end
    if (p == 2'd1 && s.acc != 2'd0 && s.hyp && !s.virt && s.sprv) begin
      p = s.spp ? 2'd1 : 2'd0; g = 1'b1;
    end
    if (s.s2) p = 2'd0;
    r  = s.s2 ? s.rgp : (g ? s.rg : s.rn);
    m  = r[63:60];
    ok = (m == 4'd0) || (m == 4'd8) || (m == 4'd9);
    lv = (m == 4'd8) ? 3'd3 : ((m == 4'd9) ? 3'd4 : 3'd0);
    e.eff   = p;
    e.widen = s.s2 ? 2'd2 : 2'd0;
    e.mxr   = s.s2 ? s.mxr_vs : s.mxr_m;
    e.sum   = s.sum;
    e.byp   = (p == 2'd3) || !s.mmu || (m == 4'd0);
    e.bad   = !e.byp && !ok;
    if (e.byp) begin
      e.pa = s.va; e.perm = 3'b111;
    end else if (ok) begin
      e.base = {r[43:0], 12'h000};
      e.lvls = lv;
      e.vab  = 7'(12 + 9 * int'(lv) + int'(e.widen));
    end
    return e;
  endfunction

  function automatic stim_t base_stim();
    stim_t s;
    s = '0;
    s.priv = 2'd1; s.acc = 2'd1; s.mmu = 1'b1;
    s.va  = 64'h0000_0012_3456_7ABC;
    s.rn  = {4'd8, 16'h0, 44'h0_0000_0123};
    s.rg  = {4'd9, 16'h0, 44'h0_0000_0456};
    s.rgp = {4'd8, 16'h0, 44'h0_0000_0789};
    return s;
  endfunction

  task automatic send(stim_t s, string tag);
    @(negedge clk);
    cur       = s;
    req_valid = 1'b1;
    exp_q.push_back(model(s));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor: pops an expectation for each result the design produces
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && out_valid) begin
        res_t  act;
        res_t  e;
        string t;
        act = {eff_priv, bypass, pa_out, perm_rwx, root_base, mode_levels,
               idx_widen, va_bits, mxr_out, sum_out, bad_mode};
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R2: unexpected result, actual out_valid=1 expected 0");
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, e);
          end
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    stim_t s;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_checks++;
    if ({out_valid, eff_priv, bypass, pa_out, perm_rwx, root_base, mode_levels,
         idx_widen, va_bits, mxr_out, sum_out, bad_mode} !== '0) begin
      n_fail++;
      $display("FAIL R1: actual out_valid=%b bypass=%b expected all zero", out_valid, bypass);
    end
    @(negedge clk);
    rst = 1'b0;

    s = base_stim(); s.priv = 2'd3;                                send(s, "R7 machine load");
    s = base_stim(); s.priv = 2'd3; s.mprv = 1; s.mpp = 2'd1;      send(s, "R3 R9 mprv to S native");
    s = base_stim(); s.priv = 2'd3; s.acc = 2'd0; s.mprv = 1;      send(s, "R3 fetch not overridden");
    idle(2);
    s = base_stim(); s.priv = 2'd3; s.acc = 2'd2; s.mprv = 1; s.mpp = 2'd0;
    s.hyp = 1; s.mpv = 1;                                          send(s, "R4 guest root four-level");
    s.hyp = 0;                                                     send(s, "R4 no hyp native");
    s = base_stim(); s.hyp = 1; s.sprv = 1; s.spp = 0;             send(s, "R5 sprv to U guest");
    s.virt = 1;                                                    send(s, "R5 virt on blocks");
    s.virt = 0; s.acc = 2'd0;                                      send(s, "R5 fetch blocks");
    s = base_stim(); s.priv = 2'd3; s.s2 = 1; s.mxr_vs = 1;        send(s, "R6 R8 stage2 from M");
    s = base_stim(); s.mxr_m = 1; s.mxr_vs = 0;                    send(s, "R8 stage1 mxr source");
    s = base_stim(); s.mmu = 0;                                    send(s, "R7 no mmu");
    s = base_stim(); s.rn[63:60] = 4'd0;                           send(s, "R7 bare mode");
    s = base_stim(); s.rn[63:60] = 4'd5;                           send(s, "R10 reserved mode");
    s = base_stim(); s.priv = 2'd3; s.rn[63:60] = 4'd5;            send(s, "R10 M bypass wins");
    s = base_stim(); s.sum = 1;                                    send(s, "R11 sum passthrough");
    s = base_stim(); s.s2 = 1; s.rgp[63:60] = 4'd9;                send(s, "R6 R9 stage2 four-level");
    idle(3);

    // R2: no result after idle cycles and all expectations consumed
    @(posedge clk);
    #1;
    n_checks++;
    if (out_valid !== 1'b0 || exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: actual out_valid=%b pending=%0d expected 0/0", out_valid, exp_q.size());
    end
    summary();
    $finish;
  end

endmodule